// File: doc/BRIEF.md
# Multi-Output Clock Prescaler

This block derives four timing outputs from one main clock. A fast strobe serves as the system-rate enable. A slow square wave serves as a low-rate timebase. Two auxiliary strobes drive peripheral logic. Every output lives in the main clock domain: the strobes are single-cycle enables and the slow output is a registered level. No derived clock is ever produced, so downstream logic stays on one clock and synthesizes cleanly.

Three byte-wide configuration registers hold the divisors, and a plain register bus reads and writes them. A write is always accepted in the cycle it is presented and a read is combinational, so the bus has no back-pressure. The fast register also carries a 3-bit multiplier mode for an oscillator-multiplier path. That path is modelled only as a multiplier status output, which is selected by `pll_sel`.

Each auxiliary divider runs only while its own enable and the main-clock-stable input are both high. Each divider loads a new divisor only when its current period ends.

Top module: `clk_prescale_unit`

## Requirements
- R1: After reset the registers read 0x4F at address 0 (fast), 0xB6 at address 1 (slow) and 0xFF at address 2 (auxiliary). During reset `fast_tick`, `slow_clk`, `aux1_tick` and `aux2_tick` are all 0.
- R2: `fast_tick` pulses for one cycle every D+1 cycles, where D is bits 3:0 of the fast register. D=0 gives a pulse every cycle.
- R3: `slow_clk` toggles every S+1 cycles, where S is the 8-bit slow register, giving a full period of 2×(S+1) cycles. S=0 toggles every cycle.
- R4: `aux1_tick` pulses every A1+1 cycles and `aux2_tick` every A2+1 cycles. A1 is bits 3:0 and A2 is bits 7:4 of the auxiliary register.
- R5: An auxiliary strobe never pulses while its enable or `main_stable` is low. The other auxiliary channel is unaffected by that enable.
- R6: While an auxiliary channel is gated off, its count returns to zero. When the gate opens, the first strobe falls in the (A+1)-th cycle, counting the cycle in which the gate opened as the first.
- R7: A divisor written mid-period does not shorten or stretch the period in progress. That period completes with the old ratio, and the next period uses the new one.
- R8: Fast register bits 6:4 hold the multiplier mode, whose legal codes are 011, 100 and 101. A write carrying any other mode code leaves the mode unchanged, while bits 3:0 of the same write still update. Bit 7 always reads 0.
- R9: `fast_mult` is 1 while `pll_sel` is 0. While `pll_sel` is 1 it is 3, 4 or 5 for mode codes 011, 100 and 101 respectively.
- R10: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 fast, 1 slow, 2 auxiliary) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| pll_sel | input | 1 | Selects the multiplier path as fast source |
| main_stable | input | 1 | Main clock is stable |
| aux1_en | input | 1 | Auxiliary channel 1 enable |
| aux2_en | input | 1 | Auxiliary channel 2 enable |
| fast_tick | output | 1 | Fast enable strobe |
| slow_clk | output | 1 | Slow square wave |
| aux1_tick | output | 1 | Auxiliary 1 enable strobe |
| aux2_tick | output | 1 | Auxiliary 2 enable strobe |
| fast_mult | output | 3 | Multiplier status of the fast source |

## Verification
The bench rewrites each divisor just after a terminal count and expects one more interval at the old ratio before the new one. A design that reloads its limit on every write would show a short or long first interval, which the check catches. Divisors of zero are exercised on the fast and slow paths, where a design that counts off by one would stall or halve the rate.

Each auxiliary channel is gated off both by dropping its enable and by dropping clock stability, and the bench then measures the delay to the first strobe after the gate reopens. A design that kept its stale count would pulse early. The bench also writes reserved mode codes and the unmapped address, and then reads the registers back. A design that lets a reserved code through would change the multiplier status, and one that decodes address 3 would corrupt a neighbouring register.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;
  localparam int FAST_W = 4;
  localparam int MODE_W = 3;
  localparam int AUX_W  = 4;
  localparam int SLOW_W = 8;
  localparam int MULT_W = 3;
  localparam int NAUX   = 2;

  localparam logic [ADDR_W-1:0] SEL_FAST = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_SLOW = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_AUX  = 2'd2;

  localparam logic [MODE_W-1:0] MODE_X3 = 3'b011;
  localparam logic [MODE_W-1:0] MODE_X4 = 3'b100;
  localparam logic [MODE_W-1:0] MODE_X5 = 3'b101;

  localparam logic [FAST_W-1:0]     RST_FAST = 4'hF;
  localparam logic [MODE_W-1:0]     RST_MODE = MODE_X4;
  localparam logic [SLOW_W-1:0]     RST_SLOW = 8'hB6;
  localparam logic [NAUX*AUX_W-1:0] RST_AUX  = 8'hFF;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return (m == MODE_X3) || (m == MODE_X4) || (m == MODE_X5);
  endfunction

  function automatic logic [MULT_W-1:0] mode_mult(input logic [MODE_W-1:0] m);
    logic [MULT_W-1:0] r;
    case (m)
      MODE_X3: r = 3'd3;
      MODE_X5: r = 3'd5;
      default: r = 3'd4;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
  import clkpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [FAST_W-1:0] fast_div,
  output logic [MODE_W-1:0] pll_mode,
  output logic [SLOW_W-1:0] slow_div,
  output logic [AUX_W-1:0]  aux1_div,
  output logic [AUX_W-1:0]  aux2_div
);
  logic wr_fast, wr_slow, wr_aux;
  logic [MODE_W-1:0] mode_wr;

  assign wr_fast = wr_en && (addr == SEL_FAST);
  assign wr_slow = wr_en && (addr == SEL_SLOW);
  assign wr_aux  = wr_en && (addr == SEL_AUX);
  assign mode_wr = wdata[FAST_W +: MODE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_div <= RST_FAST;
      pll_mode <= RST_MODE;
      slow_div <= RST_SLOW;
      aux1_div <= RST_AUX[0 +: AUX_W];
      aux2_div <= RST_AUX[AUX_W +: AUX_W];
    end else begin
      if (wr_fast) begin
        fast_div <= wdata[FAST_W-1:0];
        if (mode_ok(mode_wr)) pll_mode <= mode_wr;
      end
      if (wr_slow) slow_div <= wdata[SLOW_W-1:0];
      if (wr_aux) begin
        aux1_div <= wdata[0 +: AUX_W];
        aux2_div <= wdata[AUX_W +: AUX_W];
      end
    end
  end

  always_comb begin
    case (addr)
      SEL_FAST: rdata = {1'b0, pll_mode, fast_div};
      SEL_SLOW: rdata = slow_div;
      SEL_AUX:  rdata = {aux2_div, aux1_div};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/clkpre_tick_div.sv
module clkpre_tick_div #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_LIM = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] lim_in,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;
  logic         at_end;

  assign at_end = (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= RST_LIM;
    end else if (!run) begin
      cnt <= '0;
      lim <= lim_in;
    end else if (at_end) begin
      cnt <= '0;
      lim <= lim_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && at_end;
endmodule

// File: rtl/clkpre_halfwave.sv
module clkpre_halfwave #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_LIM = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lim_in,
  output logic         wave
);
  logic flip;

  clkpre_tick_div #(.W(W), .RST_LIM(RST_LIM)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (1'b1),
    .lim_in (lim_in),
    .tick   (flip)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    wave <= 1'b0;
    else if (flip) wave <= ~wave;
  end
endmodule

// File: rtl/clk_prescale_unit.sv
module clk_prescale_unit
  import clkpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              pll_sel,
  input  logic              main_stable,
  input  logic              aux1_en,
  input  logic              aux2_en,
  output logic              fast_tick,
  output logic              slow_clk,
  output logic              aux1_tick,
  output logic              aux2_tick,
  output logic [MULT_W-1:0] fast_mult
);
  logic [FAST_W-1:0] fast_div;
  logic [MODE_W-1:0] pll_mode;
  logic [SLOW_W-1:0] slow_div;
  logic [AUX_W-1:0]  aux_div [NAUX];
  logic [NAUX-1:0]   aux_gate;
  logic [NAUX-1:0]   aux_tick;

  clkpre_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .fast_div (fast_div),
    .pll_mode (pll_mode),
    .slow_div (slow_div),
    .aux1_div (aux_div[0]),
    .aux2_div (aux_div[1])
  );

  clkpre_tick_div #(.W(FAST_W), .RST_LIM(RST_FAST)) u_fast (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (1'b1),
    .lim_in (fast_div),
    .tick   (fast_tick)
  );

  clkpre_halfwave #(.W(SLOW_W), .RST_LIM(RST_SLOW)) u_slow (
    .clk    (clk),
    .rst_n  (rst_n),
    .lim_in (slow_div),
    .wave   (slow_clk)
  );

  assign aux_gate = {aux2_en & main_stable, aux1_en & main_stable};

  for (genvar gi = 0; gi < NAUX; gi++) begin : g_aux
    clkpre_tick_div #(.W(AUX_W), .RST_LIM(RST_AUX[gi*AUX_W +: AUX_W])) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (aux_gate[gi]),
      .lim_in (aux_div[gi]),
      .tick   (aux_tick[gi])
    );
  end

  assign aux1_tick = aux_tick[0];
  assign aux2_tick = aux_tick[1];
  assign fast_mult = pll_sel ? mode_mult(pll_mode) : MULT_W'(1);
endmodule

// File: rtl/clkpre_checker.sv
module clkpre_checker
  import clkpre_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic              pll_sel,
  input logic              main_stable,
  input logic              aux1_en,
  input logic              aux2_en,
  input logic              fast_tick,
  input logic              aux1_tick,
  input logic              aux2_tick,
  input logic [MULT_W-1:0] fast_mult
);
  localparam logic [FAST_W:0] GAP_MAX = (FAST_W+1)'(1 << FAST_W);
  logic [FAST_W:0] gap;
  logic            bad_mode_wr;

  assign bad_mode_wr = wr_en && (addr == SEL_FAST) && !mode_ok(wdata[FAST_W +: MODE_W]);

  always_ff @(posedge clk) begin
    if (!rst_n)          gap <= '0;
    else if (fast_tick)  gap <= '0;
    else if (gap != '1)  gap <= gap + 1'b1;
  end

  AST_FAST_GAP: assert property (@(posedge clk) disable iff (!rst_n) gap < GAP_MAX); // R2
  AST_AUX1_GATED: assert property (@(posedge clk) disable iff (!rst_n) !(aux1_en && main_stable) |-> !aux1_tick); // R5
  AST_AUX2_GATED: assert property (@(posedge clk) disable iff (!rst_n) !(aux2_en && main_stable) |-> !aux2_tick); // R5
  AST_RSVD_BIT: assert property (@(posedge clk) disable iff (!rst_n) (addr == SEL_FAST) |-> !rdata[BUS_W-1]); // R8
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($past(bad_mode_wr) && $past(pll_sel) && pll_sel) |-> $stable(fast_mult)); // R8
  AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pll_sel |-> (fast_mult >= 3'd3 && fast_mult <= 3'd5)); // R9
  AST_HOLE_READ: assert property (@(posedge clk) disable iff (!rst_n) (addr == 2'd3) |-> (rdata == '0)); // R10
endmodule

bind clk_prescale_unit clkpre_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .pll_sel     (pll_sel),
  .main_stable (main_stable),
  .aux1_en     (aux1_en),
  .aux2_en     (aux2_en),
  .fast_tick   (fast_tick),
  .aux1_tick   (aux1_tick),
  .aux2_tick   (aux2_tick),
  .fast_mult   (fast_mult)
);

// File: tb/tb_clk_prescale_unit.sv
`timescale 1ns/1ps
module tb_clk_prescale_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pll_sel = 1'b0;
  logic       main_stable = 1'b1;
  logic       aux1_en = 1'b0;
  logic       aux2_en = 1'b0;
  logic       fast_tick, slow_clk, aux1_tick, aux2_tick;
  logic [2:0] fast_mult;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // scoreboard: channel 0 fast, 1 slow half-period, 2 aux1, 3 aux2
  int    expq [4][$];
  string tagq [4][$];
  int    gap [4];
  bit    have [4];
  logic  slow_prev;

  always #5 clk = ~clk;

  clk_prescale_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pll_sel(pll_sel), .main_stable(main_stable),
    .aux1_en(aux1_en), .aux2_en(aux2_en), .fast_tick(fast_tick),
    .slow_clk(slow_clk), .aux1_tick(aux1_tick), .aux2_tick(aux2_tick),
    .fast_mult(fast_mult)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic push(int c, int v, string t, int n);
    for (int i = 0; i < n; i++) begin
      expq[c].push_back(v);
      tagq[c].push_back(t);
    end
  endtask

  task automatic drain(int c);
    while (expq[c].size() != 0) @(posedge clk);
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    step();
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    step();
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_fast();
    do @(negedge clk); while (!fast_tick);
  endtask

  task automatic wait_slow_flip();
    logic p;
    @(negedge clk);
    p = slow_clk;
    do @(negedge clk); while (slow_clk == p);
  endtask

  // counts cycles from the gate opening to the first aux strobe (0 if none)
  task automatic first_ticks(output int f1, output int f2);
    f1 = 0; f2 = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (aux1_tick && f1 == 0) f1 = k;
      if (aux2_tick && f2 == 0) f2 = k;
    end
  endtask

  // monitor: measures intervals between events and compares with queue
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin gap[c] = 0; have[c] = 0; end
      slow_prev = slow_clk;
    end else begin
      logic [3:0] ev;
      ev = {aux2_tick, aux1_tick, slow_clk != slow_prev, fast_tick};
      slow_prev = slow_clk;
      if (!(aux1_en && main_stable)) have[2] = 0;
      if (!(aux2_en && main_stable)) have[3] = 0;
      for (int c = 0; c < 4; c++) begin
        gap[c]++;
        if (ev[c]) begin
          if (have[c] && expq[c].size() > 0) begin
            int e;
            string t;
            e = expq[c].pop_front();
            t = tagq[c].pop_front();
            check(t, gap[c], e);
          end
          gap[c] = 0;
          have[c] = 1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int f1, f2, c1, c2;

    // R1 reset state
    repeat (4) @(posedge clk);
    #2;
    check("R1 fast_tick in reset", int'(fast_tick), 0);
    check("R1 slow_clk in reset", int'(slow_clk), 0);
    check("R1 aux1_tick in reset", int'(aux1_tick), 0);
    check("R1 aux2_tick in reset", int'(aux2_tick), 0);
    rst_n = 1'b1;
    bus_read(2'd0, rd); check("R1 fast reg", int'(rd), 8'h4F);
    bus_read(2'd1, rd); check("R1 slow reg", int'(rd), 8'hB6);
    bus_read(2'd2, rd); check("R1 aux reg", int'(rd), 8'hFF);
    check("R9 mult with pll_sel low", int'(fast_mult), 1);

    // R2, R3 default ratios
    push(0, 16, "R2", 3);
    push(1, 183, "R3", 2);
    drain(0);
    drain(1);

    // R7 fast divisor change mid-period, then R2 with D=4 and D=0
    wait_fast();
    step();
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h44;
    push(0, 16, "R7", 1);
    push(0, 5, "R2", 4);
    step();
    wr_en = 1'b0;
    drain(0);
    wait_fast();
    step();
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h40;
    push(0, 5, "R7", 1);
    push(0, 1, "R2", 5);
    step();
    wr_en = 1'b0;
    drain(0);

    // R7 and R3 on the slow path, S=3 then S=0
    wait_slow_flip();
    step();
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h03;
    push(1, 183, "R7", 1);
    push(1, 4, "R3", 3);
    step();
    wr_en = 1'b0;
    drain(1);
    wait_slow_flip();
    step();
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
    push(1, 4, "R7", 1);
    push(1, 1, "R3", 4);
    step();
    wr_en = 1'b0;
    drain(1);

    // R6 restart from zero, R4 auxiliary ratios (A1=2, A2=5)
    bus_write(2'd2, 8'h52);
    step();
    aux1_en = 1'b1; aux2_en = 1'b1;
    first_ticks(f1, f2);
    check("R6 aux1 first strobe", f1, 3);
    check("R6 aux2 first strobe", f2, 6);
    step();
    push(2, 3, "R4", 4);
    push(3, 6, "R4", 3);
    drain(2);
    drain(3);

    // R5 gating by stability, then by one enable only
    step();
    main_stable = 1'b0;
    c1 = 0; c2 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (aux1_tick) c1++;
      if (aux2_tick) c2++;
    end
    check("R5 aux1 with unstable clock", c1, 0);
    check("R5 aux2 with unstable clock", c2, 0);
    step();
    main_stable = 1'b1; aux1_en = 1'b0;
    c1 = 0; c2 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (aux1_tick) c1++;
      if (aux2_tick) c2++;
    end
    check("R5 aux1 disabled", c1, 0);
    check("R5 aux2 still running", int'(c2 > 0), 1);
    step();
    aux1_en = 1'b1;
    first_ticks(f1, f2);
    check("R6 aux1 first strobe after re-enable", f1, 3);

    // R8 and R9 mode field handling
    bus_write(2'd0, 8'h83);
    bus_read(2'd0, rd); check("R8 reserved mode kept, div updated", int'(rd), 8'h43);
    pll_sel = 1'b1;
    #1;
    check("R9 mult for mode 100", int'(fast_mult), 4);
    bus_write(2'd0, 8'hD2);
    bus_read(2'd0, rd); check("R8 legal mode 101 taken, bit7 zero", int'(rd), 8'h52);
    check("R9 mult for mode 101", int'(fast_mult), 5);
    bus_write(2'd0, 8'h32);
    check("R9 mult for mode 011", int'(fast_mult), 3);
    bus_write(2'd0, 8'h72);
    bus_read(2'd0, rd); check("R8 mode 111 rejected", int'(rd), 8'h32);
    check("R8 mult unchanged after reserved mode", int'(fast_mult), 3);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, rd); check("R8 mode 000 rejected", int'(rd), 8'h30);
    pll_sel = 1'b0;
    #1;
    check("R9 mult back to 1", int'(fast_mult), 1);

    // R10 unmapped address
    bus_write(2'd3, 8'hAA);
    bus_read(2'd3, rd); check("R10 hole reads zero", int'(rd), 0);
    bus_read(2'd0, rd); check("R10 fast reg untouched", int'(rd), 8'h30);
    bus_read(2'd1, rd); check("R10 slow reg untouched", int'(rd), 8'h00);
    bus_read(2'd2, rd); check("R10 aux reg untouched", int'(rd), 8'h52);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule